// File: doc/BRIEF.md
# Per-Well Forward Body Bias Controller

This block closes the digital side of a region-local speed compensation loop. Two on-chip delay monitors report their speed as a count of oscillation periods inside a fixed window. One monitor responds only to nMOS strength and the other only to pMOS strength. The controller compares each count with its own programmable target. It then raises a 6-bit bias code, one step at a time, for the well of the transistor type that is too slow. The nMOS monitor steers the p-well code and the pMOS monitor steers the n-well code.

Bias is only ever applied in the forward, speed-up direction. A code of zero means no bias, and a code never decreases while a run is in progress. A transistor type that already meets its target keeps a zero code. After each evaluation in which some well is still unfinished, the controller waits a programmable settling time before it asks for a new measurement. A run ends once every well has either met its target or reached full scale without meeting it.

A run begins with a start pulse. The controller raises `meas_req` when it wants a measurement. The monitor side answers with the two counts and a one-cycle `mon_valid` strobe.

Top module: `bias_comp_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both codes are 0 and `busy`, `done`, `meas_req`, `pw_sat` and `nw_sat` are all 0.
- R2: A `start` pulse seen while idle or done clears both codes and both saturation flags. `meas_req` and `busy` are 1 in the cycle after that edge.
- R3: An accepted measurement (`mon_valid` while `meas_req` is 1) raises a well's code by exactly 1 in the next cycle when that well's count is below its target and its code is below 63.
- R4: An accepted measurement with count >= target leaves that well's code unchanged. The code then holds until the next start.
- R5: The two wells are independent. A well whose monitor meets its target at code 0 keeps code 0 while the other well ramps.
- R6: When a well's code is 63 and its count is still below target at an accepted measurement, its saturation flag is set and its code stays 63.
- R7: After an accepted measurement that leaves any well unfinished, `meas_req` stays low for exactly `settle_len`+2 cycles before it rises again.
- R8: When every well is met or saturated, `done` rises in the cycle after the deciding evaluation, `busy` falls, and both stay that way until the next start. The final code of each well is the smallest c in 0..63 with count(c) >= target, or 63 if no such c exists.
- R9: `mon_valid` while `meas_req` is 0 changes nothing, and `start` while `busy` is 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a compensation run from code 0 |
| settle_len | input | 8 | Settling wait after a step, in cycles minus one |
| mon_valid | input | 1 | One-cycle strobe: both monitor counts are valid |
| nmon_cnt | input | 12 | Period count of the nMOS-sensitive monitor |
| pmon_cnt | input | 12 | Period count of the pMOS-sensitive monitor |
| nmon_target | input | 12 | Minimum acceptable nMOS monitor count |
| pmon_target | input | 12 | Minimum acceptable pMOS monitor count |
| meas_req | output | 1 | Controller awaits a measurement |
| pw_code | output | 6 | p-well forward bias code (driven by nMOS monitor) |
| nw_code | output | 6 | n-well forward bias code (driven by pMOS monitor) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pw_sat | output | 1 | p-well reached 63 without meeting its target |
| nw_sat | output | 1 | n-well reached 63 without meeting its target |

## Verification
Both wells are evaluated on the same measurement strobe, so one well stepping, one well meeting its target and one well saturating can all happen in the same cycle. The sweep is built to provoke exactly that. Linear monitor models with different slopes for each well are swept over targets that are met at code 0, met part way up the range, met exactly at code 63, and never met. This gives every mix of step, hold and saturate on a shared evaluation. After every strobe the bench compares each code with a step-by-step model, and at the end of the run with the closed-form smallest-code answer. Any cross-talk between the loops, or a finish decision taken before both wells have settled, shows up as a code or flag mismatch.

// File: rtl/bias_comp_pkg.sv
// Package: shared types for the body bias controller.
// Assumes: nothing; pure type definitions.
package bias_comp_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_MEAS   = 3'd1,
        SEQ_CHECK  = 3'd2,
        SEQ_SETTLE = 3'd3,
        SEQ_DONE   = 3'd4
    } seq_state_t;

    localparam int unsigned N_WELLS = 2;
    localparam int unsigned WELL_P  = 0;  // p-well, steered by nMOS monitor
    localparam int unsigned WELL_N  = 1;  // n-well, steered by pMOS monitor

endpackage

// File: rtl/bias_well_loop.sv
// Module: one well's forward-bias stepping loop.
// On each evaluation strobe it compares the monitor count with the target.
// If the monitor is fast enough, the well is marked met and the code freezes.
// If it is slow and the code is below full scale, the code rises by one.
// If it is slow at full scale, the well is marked saturated.
// Assumes: eval is a single-cycle strobe; clear has priority over eval.
module bias_well_loop #(
    parameter int unsigned CODE_W = 6,
    parameter int unsigned CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              eval,
    input  logic [CNT_W-1:0]  mon_cnt,
    input  logic [CNT_W-1:0]  target,
    output logic [CODE_W-1:0] code,
    output logic              met,
    output logic              sat
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic slow;
    logic finished;

    // Purpose: classify the current measurement and the loop's own state.
    always_comb begin
        slow     = (mon_cnt < target);
        finished = met | sat;
    end

    // Purpose: step, freeze or saturate the bias code on each evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code <= '0;
            met  <= 1'b0;
            sat  <= 1'b0;
        end else if (eval && !finished) begin
            if (!slow) begin
                met <= 1'b1;
            end else if (code == CODE_MAX) begin
                sat <= 1'b1;
            end else begin
                code <= code + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bias_settle_timer.sv
// Module: settling-interval down-counter.
// load captures the length; while run is high the count falls to zero.
// expired is high while running with the count at zero.
// Assumes: load and run are never high together.
module bias_settle_timer #(
    parameter int unsigned SET_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SET_W-1:0] len,
    output logic             expired
);
    logic [SET_W-1:0] remain;

    // Purpose: load or count down the settle interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Purpose: flag the last cycle of the settle interval.
    always_comb begin
        expired = run && (remain == '0);
    end
endmodule

// File: rtl/bias_seq.sv
// Module: run sequencer for the compensation loop.
// It moves through idle, measure, check, settle and done.
// It issues the clear, evaluation, timer-load and measurement-request controls.
// Assumes: all_fin reflects the well flags updated by the previous evaluation.
module bias_seq
    import bias_comp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mon_valid,
    input  logic all_fin,
    input  logic expired,
    output logic clear,
    output logic eval,
    output logic load,
    output logic run,
    output logic meas_req,
    output logic busy,
    output logic done
);
    seq_state_t state, state_nx;

    // Purpose: next-state and control decode.
    always_comb begin
        state_nx = state;
        clear    = 1'b0;
        eval     = 1'b0;
        load     = 1'b0;
        case (state)
            SEQ_IDLE, SEQ_DONE: begin
                if (start) begin
                    clear    = 1'b1;
                    state_nx = SEQ_MEAS;
                end
            end
            SEQ_MEAS: begin
                if (mon_valid) begin
                    eval     = 1'b1;
                    state_nx = SEQ_CHECK;
                end
            end
            SEQ_CHECK: begin
                if (all_fin) begin
                    state_nx = SEQ_DONE;
                end else begin
                    load     = 1'b1;
                    state_nx = SEQ_SETTLE;
                end
            end
            SEQ_SETTLE: begin
                if (expired) state_nx = SEQ_MEAS;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // Purpose: Moore outputs.
    always_comb begin
        run      = (state == SEQ_SETTLE);
        meas_req = (state == SEQ_MEAS);
        busy     = (state == SEQ_MEAS) || (state == SEQ_CHECK) || (state == SEQ_SETTLE);
        done     = (state == SEQ_DONE);
    end
endmodule

// File: rtl/bias_comp_ctrl.sv
// Module: top of the per-well forward body bias controller.
// Two independent stepping loops share one sequencer and one settle timer.
// Index WELL_P holds the p-well code, driven by the nMOS monitor.
// Index WELL_N holds the n-well code, driven by the pMOS monitor.
// Assumes: the monitor counts are stable in the cycle mon_valid is high.
module bias_comp_ctrl
    import bias_comp_pkg::*;
#(
    parameter int unsigned CODE_W = 6,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SET_W-1:0]  settle_len,
    input  logic              mon_valid,
    input  logic [CNT_W-1:0]  nmon_cnt,
    input  logic [CNT_W-1:0]  pmon_cnt,
    input  logic [CNT_W-1:0]  nmon_target,
    input  logic [CNT_W-1:0]  pmon_target,
    output logic              meas_req,
    output logic [CODE_W-1:0] pw_code,
    output logic [CODE_W-1:0] nw_code,
    output logic              busy,
    output logic              done,
    output logic              pw_sat,
    output logic              nw_sat
);
    logic [CNT_W-1:0]  cnt_arr  [N_WELLS];
    logic [CNT_W-1:0]  tgt_arr  [N_WELLS];
    logic [CODE_W-1:0] code_arr [N_WELLS];
    logic [N_WELLS-1:0] met_v, sat_v;
    logic clear, eval, load, run, expired, all_fin;

    // Purpose: route each monitor to the well it controls.
    always_comb begin
        cnt_arr[WELL_P] = nmon_cnt;
        tgt_arr[WELL_P] = nmon_target;
        cnt_arr[WELL_N] = pmon_cnt;
        tgt_arr[WELL_N] = pmon_target;
        all_fin         = &(met_v | sat_v);
    end

    for (genvar w = 0; w < N_WELLS; w++) begin : g_well
        bias_well_loop #(.CODE_W(CODE_W), .CNT_W(CNT_W)) loop_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .eval    (eval),
            .mon_cnt (cnt_arr[w]),
            .target  (tgt_arr[w]),
            .code    (code_arr[w]),
            .met     (met_v[w]),
            .sat     (sat_v[w])
        );
    end

    bias_settle_timer #(.SET_W(SET_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .run     (run),
        .len     (settle_len),
        .expired (expired)
    );

    bias_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mon_valid (mon_valid),
        .all_fin   (all_fin),
        .expired   (expired),
        .clear     (clear),
        .eval      (eval),
        .load      (load),
        .run       (run),
        .meas_req  (meas_req),
        .busy      (busy),
        .done      (done)
    );

    // Purpose: expose per-well results on named ports.
    always_comb begin
        pw_code = code_arr[WELL_P];
        nw_code = code_arr[WELL_N];
        pw_sat  = sat_v[WELL_P];
        nw_sat  = sat_v[WELL_N];
    end
endmodule

// File: rtl/bias_comp_ctrl_chk.sv
// Module: property checker for bias_comp_ctrl, bound to every instance.
// Assumes: reset is held low for at least one clock at start-up.
module bias_comp_ctrl_chk #(
    parameter int unsigned CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mon_valid,
    input logic              meas_req,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] pw_code,
    input logic [CODE_W-1:0] nw_code,
    input logic              pw_sat,
    input logic              nw_sat
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    // R1: reset clears the codes and flags
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pw_code == '0 && nw_code == '0 && !done && !busy && !pw_sat && !nw_sat));

    // R3: a code change during a run is a single upward step
    a_r3_pw_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(busy) && pw_code != $past(pw_code))
            |-> (pw_code - $past(pw_code)) == CODE_W'(1));
    a_r3_nw_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(busy) && nw_code != $past(nw_code))
            |-> (nw_code - $past(nw_code)) == CODE_W'(1));

    // R9: codes move during a run only after an accepted measurement
    a_r9_step_needs_meas: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(busy) && (pw_code != $past(pw_code) || nw_code != $past(nw_code)))
            |-> $past(mon_valid && meas_req));

    // R6: saturation only at full scale
    a_r6_pw_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
        pw_sat |-> pw_code == CODE_MAX);
    a_r6_nw_sat_full: assert property (@(posedge clk) disable iff (!rst_n)
        nw_sat |-> nw_code == CODE_MAX);

    // R8: done excludes busy and requests, and codes are frozen while done
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !meas_req));
    a_r8_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && done && $past(done)) |-> ($stable(pw_code) && $stable(nw_code)));
endmodule

bind bias_comp_ctrl bias_comp_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_valid (mon_valid),
    .meas_req  (meas_req),
    .busy      (busy),
    .done      (done),
    .pw_code   (pw_code),
    .nw_code   (nw_code),
    .pw_sat    (pw_sat),
    .nw_sat    (nw_sat)
);

// File: tb/bias_comp_ctrl_tb_top.sv
// Bench: sweeps linear monitor models against many targets and settle lengths.
// Every step and every final code is checked against arithmetic expectations.
module bias_comp_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  settle_len = '0;
    logic        mon_valid = 1'b0;
    logic [11:0] nmon_cnt = '0, pmon_cnt = '0, nmon_target = '0, pmon_target = '0;
    logic        meas_req, busy, done, pw_sat, nw_sat;
    logic [5:0]  pw_code, nw_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;  // 50 MHz

    bias_comp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_len(settle_len),
        .mon_valid(mon_valid), .nmon_cnt(nmon_cnt), .pmon_cnt(pmon_cnt),
        .nmon_target(nmon_target), .pmon_target(pmon_target),
        .meas_req(meas_req), .pw_code(pw_code), .nw_code(nw_code),
        .busy(busy), .done(done), .pw_sat(pw_sat), .nw_sat(nw_sat)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // smallest code meeting target, 64 if none
    function automatic int need_code(input int base, input int gain, input int tgt);
        for (int c = 0; c < 64; c++) if (base + gain * c >= tgt) return c;
        return 64;
    endfunction

    function automatic int step_model(input int code, input int cnt, input int tgt, inout bit fin, inout bit sat);
        if (fin) return code;
        if (cnt >= tgt) begin fin = 1; return code; end
        if (code == 63) begin fin = 1; sat = 1; return code; end
        return code + 1;
    endfunction

    // One full run; poke_busy injects a start pulse during the first settle gap.
    task automatic run_case(input int nb, input int ng, input int nt,
                            input int pb, input int pg, input int pt,
                            input int sl, input bit poke_busy);
        int  ep = 0, en = 0, gap = -1, guard = 0;
        bit  pf = 0, ps = 0, nf = 0, ns = 0, poked = 0;
        int  cn, cp;
        nmon_target = 12'(nt); pmon_target = 12'(pt); settle_len = 8'(sl);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R2 meas_req after start", int'(meas_req), 1);
        check("R2 codes cleared", int'(pw_code) + int'(nw_code) + int'(pw_sat) + int'(nw_sat), 0);
        while (!done && guard < 20000) begin
            guard++;
            if (meas_req) begin
                if (gap >= 0) check("R7 settle gap", gap, sl + 2);
                gap = -1;
                cn = nb + ng * int'(pw_code);
                cp = pb + pg * int'(nw_code);
                nmon_cnt = 12'(cn); pmon_cnt = 12'(cp);
                mon_valid = 1'b1;
                @(negedge clk); mon_valid = 1'b0;
                ep = step_model(ep, cn, nt, pf, ps);
                en = step_model(en, cp, pt, nf, ns);
                check("R3/R4/R5 pw step", int'(pw_code), ep);
                check("R3/R4/R5 nw step", int'(nw_code), en);
                gap = 1;
            end else begin
                if (poke_busy && !poked && busy && gap == 2) begin
                    start = 1'b1; @(negedge clk); start = 1'b0; poked = 1;
                    check("R9 start while busy ignored pw", int'(pw_code), ep);
                    check("R9 start while busy ignored busy", int'(busy), 1);
                    gap++;
                end else begin
                    @(negedge clk);
                    if (gap >= 0 && !meas_req && !done) gap++;
                end
            end
        end
        check("R8 done reached", int'(done), 1);
        check("R8 busy low", int'(busy), 0);
        begin
            int xn = need_code(nb, ng, nt);
            int xp = need_code(pb, pg, pt);
            check("R8 pw final code", int'(pw_code), (xn > 63) ? 63 : xn);
            check("R8 nw final code", int'(nw_code), (xp > 63) ? 63 : xp);
            check("R6 pw sat", int'(pw_sat), int'(xn > 63));
            check("R6 nw sat", int'(nw_sat), int'(xp > 63));
        end
        // R9: a stray strobe while done changes nothing
        nmon_cnt = '0; pmon_cnt = '0; mon_valid = 1'b1;
        @(negedge clk); mon_valid = 1'b0;
        @(negedge clk);
        check("R9 stray strobe pw", int'(pw_code), ep);
        check("R9 stray strobe nw", int'(nw_code), en);
        check("R9 still done", int'(done), 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int ntg[6] = '{50, 100, 101, 205, 415, 420};
        int ptg[4] = '{150, 203, 389, 400};
        int k = 0;
        repeat (3) @(negedge clk);
        check("R1 reset codes", int'(pw_code) + int'(nw_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags after reset", int'(busy) + int'(done) + int'(meas_req) + int'(pw_sat) + int'(nw_sat), 0);
        // R9: strobe while idle
        mon_valid = 1'b1; @(negedge clk); mon_valid = 1'b0; @(negedge clk);
        check("R9 idle strobe ignored", int'(busy) + int'(pw_code), 0);
        // R5: slow nMOS, fast pMOS -> only p-well moves
        run_case(100, 5, 200, 300, 3, 150, 1, 1'b0);
        check("R5 n-well untouched", int'(nw_code), 0);
        // R9: start while busy
        run_case(100, 5, 150, 200, 3, 260, 3, 1'b1);
        // sweep: met at 0, mid-range, exactly 63, never
        foreach (ntg[i]) foreach (ptg[j]) begin
            run_case(100, 5, ntg[i], 200, 3, ptg[j], k % 4, 1'b0);
            k++;
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule